// File: doc/BRIEF.md
# Register-Command Playback Controller

This block replays a list of register writes that software has placed in memory. The list drives the sub-blocks of an accelerator pipeline. Software first writes the buffer's base address and the number of entries. It then sets the start bit. The controller fetches the 64-bit entries one by one over a valid/ready memory read port, splits each entry into a destination tag, a register offset and a 32-bit value, and forwards armed writes onto a per-destination write bus. The accelerator sub-blocks behave as write sinks on that bus.

Every entry carries a destination tag whose low bit arms it. An entry that is not armed is read and counted but causes no write. A correct list closes with a fixed barrier entry and then a write of the start word to the controller's own enable offset. When that tail is present and last, the controller pulses a pipeline-start strobe. Any other tail, and any armed write to an unknown destination, sets a sticky error. A second controller offset selects one of two ping-pong channels and can make the channel flip at every successful start. Tasks run strictly one after another. A new start is accepted only when the controller is idle.

Top module: `cmdpb_top`

## Requirements
- R1: Each 64-bit entry splits into tag = bits [63:48], value = bits [47:16] and offset = bits [15:0]. An armed entry whose tag is 0x0201, 0x0801, 0x1001 or 0x4001 drives a one-cycle pulse on write lane 0, 1, 2 or 3. The pulse carries `wr_addr` = offset and `wr_data` = value and appears in the cycle after the memory response is taken.
- R2: An entry with bit 48 (tag bit 0, the arming bit) clear causes no write, no error and no channel change, but it still counts as consumed.
- R3: A config write with `cfg_sel` = 2 and bit 0 set starts playback from the stored base address when the controller is idle. The same write is ignored while `stat_busy` is high, and so is a change of base made while busy.
- R4: With amount register `cfg_sel` = 1 holding A, exactly A+1 entries are fetched from addresses base, base+8, base+16 and so on, in ascending order. `stat_count` ends at A+1.
- R5: `mem_req_addr` and `mem_req_valid` stay steady until `mem_req_ready` is seen. Any number of wait cycles before ready or before `mem_rsp_valid` leaves the written results unchanged.
- R6: If the last entry is tag 0x0081, offset 0x0008, value 0x0000001D, and the entry just before it is the armed barrier 0x0041 (offset and value are free), `pipe_start` pulses once and no error is raised.
- R7: If the last entry is not such a start write, or the start write lacks the armed barrier immediately before it, or a start write appears before the last entry, then that write does not pulse `pipe_start` and the sticky error is set.
- R8: An armed entry whose tag is none of the four lane tags, the barrier or 0x0081, or which has tag 0x0081 with an offset other than 0x0004 or 0x0008, produces no write and sets the sticky error.
- R9: `done_irq` rises after the last entry and stays high until a `cfg_sel` = 3 write with bit 0 set. `err_irq` stays high until a `cfg_sel` = 3 write with bit 1 set. A new set wins over a clear in the same cycle.
- R10: An armed write with tag 0x0081 at offset 0x0004 loads `chan_sel` from value bit 0 and stores value bit 1 as an auto-flip flag. While that flag is set, every `pipe_start` inverts `chan_sel`.
- R11: At most one write lane is active in any cycle, and writes leave in buffer order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_sel | input | 2 | Config register: 0 base, 1 amount, 2 enable, 3 status clear |
| cfg_wdata | input | 32 | Config write data |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | ADDR_W | Byte address of entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry read data |
| wr_valid | output | 4 | Per-lane write strobes |
| wr_addr | output | 16 | Register offset of write |
| wr_data | output | 32 | Write value |
| pipe_start | output | 1 | Pipeline start pulse |
| chan_sel | output | 1 | Ping-pong channel select |
| stat_busy | output | 1 | Playback in progress |
| stat_count | output | CNT_W+1 | Entries consumed in current or last run |
| done_irq | output | 1 | Sticky done flag / interrupt |
| err_irq | output | 1 | Sticky error flag / interrupt |

## Verification
Some properties hold on every cycle, and the embedded assertions check those. They cover the held request under back-pressure, the one-hot write lanes, the bound on the fetch index, the rule that a start pulse coincides with the final entry and never with an error, and the stickiness of the status flags. The bench scenarios show what needs a whole run to judge. That includes the full order and content of the forwarded writes, the skipping of unarmed entries, every malformed-tail case, the rejection of a start issued while busy, and the ping-pong channel across several tasks. These are swept over entry counts and memory wait patterns.

// File: rtl/cmdpb_pkg.sv
package cmdpb_pkg;

    localparam int NLANE = 4;

    localparam logic [15:0] TGT_BARRIER  = 16'h0041;
    localparam logic [15:0] TGT_CTRL     = 16'h0081;
    localparam logic [15:0] CTRL_PTR_OFS = 16'h0004;
    localparam logic [15:0] CTRL_RUN_OFS = 16'h0008;
    localparam logic [31:0] RUN_WORD     = 32'h0000_001D;

    // armed tags of the write lanes, lane 0 in the low slot
    localparam logic [NLANE-1:0][15:0] LANE_TGT =
        {16'h4001, 16'h1001, 16'h0801, 16'h0201};

    typedef enum logic [1:0] {
        SEL_BASE   = 2'd0,
        SEL_AMOUNT = 2'd1,
        SEL_ENABLE = 2'd2,
        SEL_STATUS = 2'd3
    } cfg_sel_e;

    typedef enum logic [1:0] {
        F_IDLE = 2'd0,
        F_REQ  = 2'd1,
        F_WAIT = 2'd2
    } fetch_st_e;

    typedef struct packed {
        logic [15:0] tgt;
        logic [31:0] val;
        logic [15:0] ofs;
    } cmd_entry_t;

endpackage

// File: rtl/cmdpb_regs.sv
module cmdpb_regs
    import cmdpb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    input  logic              busy_i,
    input  logic              done_set_i,
    input  logic              err_set_i,
    output logic [ADDR_W-1:0] base_o,
    output logic [CNT_W-1:0]  amount_o,
    output logic              start_o,
    output logic              done_o,
    output logic              err_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [CNT_W-1:0]  amount;
        logic              done;
        logic              err;
    } regs_t;

    regs_t    r_d, r_q;
    cfg_sel_e sel;
    logic     clr_done, clr_err;

    always_comb begin
        r_d      = r_q;
        sel      = cfg_sel_e'(cfg_sel);
        start_o  = cfg_we && (sel == SEL_ENABLE) && cfg_wdata[0] && !busy_i;
        clr_done = cfg_we && (sel == SEL_STATUS) && cfg_wdata[0];
        clr_err  = cfg_we && (sel == SEL_STATUS) && cfg_wdata[1];
        if (cfg_we && sel == SEL_BASE)   r_d.base   = cfg_wdata[ADDR_W-1:0];
        if (cfg_we && sel == SEL_AMOUNT) r_d.amount = cfg_wdata[CNT_W-1:0];
        if (clr_done)   r_d.done = 1'b0;
        if (clr_err)    r_d.err  = 1'b0;
        if (done_set_i) r_d.done = 1'b1;
        if (err_set_i)  r_d.err  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign base_o   = r_q.base;
    assign amount_o = r_q.amount;
    assign done_o   = r_q.done;
    assign err_o    = r_q.err;

    // R9: flags stay set until their clear bit is written
    a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.done && !(cfg_we && cfg_sel == 2'd3 && cfg_wdata[0])) |=> r_q.done);
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.err && !(cfg_we && cfg_sel == 2'd3 && cfg_wdata[1])) |=> r_q.err);

endmodule

// File: rtl/cmdpb_fetch.sv
module cmdpb_fetch
    import cmdpb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [CNT_W-1:0]  amount_i,
    output logic              mem_req_valid_o,
    input  logic              mem_req_ready_i,
    output logic [ADDR_W-1:0] mem_req_addr_o,
    input  logic              mem_rsp_valid_i,
    input  logic [63:0]       mem_rsp_data_i,
    output logic              entry_valid_o,
    output cmd_entry_t        entry_o,
    output logic              entry_last_o,
    output logic              busy_o,
    output logic [CNT_W:0]    count_o
);

    localparam int ENTRY_SHIFT = 3;

    typedef struct packed {
        fetch_st_e         st;
        logic [ADDR_W-1:0] base;
        logic [CNT_W-1:0]  last;
        logic [CNT_W:0]    idx;
    } fetch_t;

    fetch_t f_d, f_q;
    logic   last_hit;

    always_comb begin
        f_d           = f_q;
        entry_valid_o = 1'b0;
        last_hit      = (f_q.idx == {1'b0, f_q.last});
        unique case (f_q.st)
            F_IDLE: begin
                if (start_i) begin
                    f_d.st   = F_REQ;
                    f_d.base = base_i;
                    f_d.last = amount_i;
                    f_d.idx  = '0;
                end
            end
            F_REQ: begin
                if (mem_req_ready_i) f_d.st = F_WAIT;
            end
            F_WAIT: begin
                if (mem_rsp_valid_i) begin
                    entry_valid_o = 1'b1;
                    f_d.idx       = f_q.idx + 1'b1;
                    f_d.st        = last_hit ? F_IDLE : F_REQ;
                end
            end
            default: f_d.st = F_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{st: F_IDLE, default: '0};
        else        f_q <= f_d;
    end

    assign mem_req_valid_o = (f_q.st == F_REQ);
    assign mem_req_addr_o  = f_q.base + (ADDR_W'(f_q.idx) << ENTRY_SHIFT);
    assign entry_o         = cmd_entry_t'(mem_rsp_data_i);
    assign entry_last_o    = last_hit;
    assign busy_o          = (f_q.st != F_IDLE);
    assign count_o         = f_q.idx;

    // R5: a pending request is held with a steady address
    a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));
    // R4: the index never runs past amount + 1
    a_r4_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= ({1'b0, f_q.last} + 1'b1));
    // R4: a non-final entry is followed by the next request
    a_r4_next_req: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_valid_o && !entry_last_o) |=> mem_req_valid_o);

endmodule

// File: rtl/cmdpb_decode.sv
module cmdpb_decode
    import cmdpb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             entry_valid_i,
    input  cmd_entry_t       entry_i,
    input  logic             entry_last_i,
    output logic [NLANE-1:0] wr_valid_o,
    output logic [15:0]      wr_addr_o,
    output logic [31:0]      wr_data_o,
    output logic             pipe_start_o,
    output logic             chan_sel_o,
    output logic             err_set_o,
    output logic             done_set_o
);

    typedef struct packed {
        logic [NLANE-1:0] wr_valid;
        logic [15:0]      wr_addr;
        logic [31:0]      wr_data;
        logic             pipe_start;
        logic             err_set;
        logic             done_set;
        logic             chan;
        logic             auto_flip;
        logic             barrier_seen;
    } dec_t;

    dec_t             s_d, s_q;
    logic [NLANE-1:0] lane_hit;
    logic             armed, is_ctrl, trig_ok;

    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        assign lane_hit[i] = (entry_i.tgt == LANE_TGT[i]);
    end

    always_comb begin
        s_d            = s_q;
        s_d.wr_valid   = '0;
        s_d.pipe_start = 1'b0;
        s_d.err_set    = 1'b0;
        s_d.done_set   = 1'b0;
        armed          = entry_i.tgt[0];
        is_ctrl        = (entry_i.tgt == TGT_CTRL);
        trig_ok        = is_ctrl && (entry_i.ofs == CTRL_RUN_OFS) &&
                         (entry_i.val == RUN_WORD) && s_q.barrier_seen && entry_last_i;
        if (start_i) s_d.barrier_seen = 1'b0;
        if (entry_valid_i) begin
            s_d.barrier_seen = 1'b0;
            s_d.done_set     = entry_last_i;
            if (!armed) begin
                // skipped entry: counted upstream, no effect here
            end else if (|lane_hit) begin
                s_d.wr_valid = lane_hit;
                s_d.wr_addr  = entry_i.ofs;
                s_d.wr_data  = entry_i.val;
            end else if (entry_i.tgt == TGT_BARRIER) begin
                s_d.barrier_seen = 1'b1;
            end else if (is_ctrl && entry_i.ofs == CTRL_PTR_OFS) begin
                s_d.chan      = entry_i.val[0];
                s_d.auto_flip = entry_i.val[1];
            end else if (trig_ok) begin
                s_d.pipe_start = 1'b1;
                if (s_q.auto_flip) s_d.chan = ~s_q.chan;
            end else begin
                s_d.err_set = 1'b1;
            end
            if (entry_last_i && !trig_ok) s_d.err_set = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wr_valid_o   = s_q.wr_valid;
    assign wr_addr_o    = s_q.wr_addr;
    assign wr_data_o    = s_q.wr_data;
    assign pipe_start_o = s_q.pipe_start;
    assign chan_sel_o   = s_q.chan;
    assign err_set_o    = s_q.err_set;
    assign done_set_o   = s_q.done_set;

    // R11: never more than one lane strobe
    a_r11_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_valid_o));
    // R1: a write only follows an accepted entry
    a_r1_write_source: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_valid_o) |-> $past(entry_valid_i));
    // R6: the start pulse belongs to the final entry
    a_r6_start_is_last: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_start_o |-> done_set_o);
    // R7: a granted start never comes with an error
    a_r7_start_clean: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_start_o |-> !err_set_o);

endmodule

// File: rtl/cmdpb_top.sv
module cmdpb_top
    import cmdpb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [63:0]       mem_rsp_data,
    output logic [NLANE-1:0]  wr_valid,
    output logic [15:0]       wr_addr,
    output logic [31:0]       wr_data,
    output logic              pipe_start,
    output logic              chan_sel,
    output logic              stat_busy,
    output logic [CNT_W:0]    stat_count,
    output logic              done_irq,
    output logic              err_irq
);

    logic [ADDR_W-1:0] base;
    logic [CNT_W-1:0]  amount;
    logic              start, done_set, err_set;
    logic              entry_valid, entry_last;
    cmd_entry_t        entry;

    cmdpb_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .busy_i     (stat_busy),
        .done_set_i (done_set),
        .err_set_i  (err_set),
        .base_o     (base),
        .amount_o   (amount),
        .start_o    (start),
        .done_o     (done_irq),
        .err_o      (err_irq)
    );

    cmdpb_fetch #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_fetch (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start),
        .base_i          (base),
        .amount_i        (amount),
        .mem_req_valid_o (mem_req_valid),
        .mem_req_ready_i (mem_req_ready),
        .mem_req_addr_o  (mem_req_addr),
        .mem_rsp_valid_i (mem_rsp_valid),
        .mem_rsp_data_i  (mem_rsp_data),
        .entry_valid_o   (entry_valid),
        .entry_o         (entry),
        .entry_last_o    (entry_last),
        .busy_o          (stat_busy),
        .count_o         (stat_count)
    );

    cmdpb_decode u_decode (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .entry_valid_i (entry_valid),
        .entry_i       (entry),
        .entry_last_i  (entry_last),
        .wr_valid_o    (wr_valid),
        .wr_addr_o     (wr_addr),
        .wr_data_o     (wr_data),
        .pipe_start_o  (pipe_start),
        .chan_sel_o    (chan_sel),
        .err_set_o     (err_set),
        .done_set_o    (done_set)
    );

endmodule

// File: tb/cmdpb_top_tb.sv
module cmdpb_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = 64'd0;
    logic [3:0]  wr_valid;
    logic [15:0] wr_addr;
    logic [31:0] wr_data;
    logic        pipe_start, chan_sel, stat_busy, done_irq, err_irq;
    logic [8:0]  stat_count;

    cmdpb_top u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .pipe_start(pipe_start), .chan_sel(chan_sel), .stat_busy(stat_busy),
        .stat_count(stat_count), .done_irq(done_irq), .err_irq(err_irq)
    );

    always #10 clk = ~clk;   // 50 MHz

    localparam logic [15:0] BAR = 16'h0041, CTL = 16'h0081, UNK = 16'h0301;
    logic [15:0] lane_tag [4];
    initial begin
        lane_tag[0] = 16'h0201; lane_tag[1] = 16'h0801;
        lane_tag[2] = 16'h1001; lane_tag[3] = 16'h4001;
    end

    int checks = 0, errors = 0;
    logic [63:0] mem [64];
    int exp_n;
    logic [1:0]  e_lane [64];
    logic [15:0] e_addr [64];
    logic [31:0] e_data [64];
    int obs_n, pcount, rk, wm_g;
    logic [1:0]  o_lane [64];
    logic [15:0] o_addr [64];
    logic [31:0] o_data [64];
    logic [31:0] cur_base = 32'd0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ent(input logic [15:0] t, input logic [31:0] v, input logic [15:0] o);
        return {t, v, o};
    endfunction

    task automatic put(input logic [31:0] base, input int i, input logic [63:0] w);
        mem[((base >> 3) + i) % 64] = w;
        for (int l = 0; l < 4; l++)
            if (w[63:48] == lane_tag[l]) begin
                e_lane[exp_n] = 2'(l); e_addr[exp_n] = w[15:0]; e_data[exp_n] = w[47:16];
                exp_n++;
            end
    endtask

    task automatic put_tail(input logic [31:0] base, input int i);
        put(base, i, ent(BAR, 32'h0, 16'h0));
        put(base, i + 1, ent(CTL, 32'h1D, 16'h0008));
    endtask

    task automatic cfg_write(input logic [1:0] s, input logic [31:0] d);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // write monitor
    always @(negedge clk) begin
        if (rst_n && |wr_valid) begin
            chk("R11 one lane", 64'($countones(wr_valid)), 64'd1);
            for (int l = 0; l < 4; l++)
                if (wr_valid[l]) o_lane[obs_n % 64] = 2'(l);
            o_addr[obs_n % 64] = wr_addr; o_data[obs_n % 64] = wr_data;
            obs_n++;
        end
        if (rst_n && pipe_start) pcount++;
    end

    // memory responder
    logic        acc_q = 1'b0;
    logic [31:0] acc_addr = 32'd0;
    logic        pend = 1'b0;
    int          dly = 0, gap = 0;
    always @(posedge clk) begin
        acc_q    <= mem_req_valid && mem_req_ready;
        acc_addr <= mem_req_addr;
    end
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (acc_q) begin
            chk("R4 address order", 64'(acc_addr), 64'(cur_base + 32'(8 * rk)));
            rk++;
            pend = 1'b1; dly = wm_g; gap = wm_g; mem_req_ready = 1'b0;
        end
        if (pend) begin
            if (dly == 0) begin
                mem_rsp_valid = 1'b1; mem_rsp_data = mem[acc_addr[8:3]]; pend = 1'b0;
            end else dly--;
        end else if (!mem_req_ready) begin
            if (gap == 0) mem_req_ready = 1'b1; else gap--;
        end
    end

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic run(input string tag, input int n, input int wm, input logic [31:0] base,
                       input logic exp_err, input int exp_pipe, input logic poke);
        int t = 0;
        cur_base = base; rk = 0; obs_n = 0; pcount = 0; wm_g = wm;
        cfg_write(2'd0, base);
        cfg_write(2'd1, 32'(n - 1));
        cfg_write(2'd2, 32'd1);
        if (poke) begin
            repeat (3) @(negedge clk);
            cfg_write(2'd0, base + 32'h200);
            cfg_write(2'd2, 32'd1);            // R3: ignored while busy
        end
        while (!done_irq && t < 4000) begin @(negedge clk); t++; end
        chk({"R9 done ", tag}, 64'(done_irq), 64'd1);
        chk({"R9 idle ", tag}, 64'(stat_busy), 64'd0);
        chk({"R4 count ", tag}, 64'(stat_count), 64'(n));
        chk({"R6 start pulses ", tag}, 64'(pcount), 64'(exp_pipe));
        chk({"R7 R8 error flag ", tag}, 64'(err_irq), 64'(exp_err));
        chk({"R1 R2 write count ", tag}, 64'(obs_n), 64'(exp_n));
        for (int k = 0; k < exp_n && k < obs_n; k++)
            chk({"R1 R11 write ", tag}, {14'd0, o_lane[k], o_addr[k], o_data[k]},
                {14'd0, e_lane[k], e_addr[k], e_data[k]});
        repeat (3) @(negedge clk);
        chk({"R9 done held ", tag}, 64'(done_irq), 64'd1);
        cfg_write(2'd3, 32'd3);
        chk({"R9 cleared ", tag}, {62'd0, done_irq, err_irq}, 64'd0);
        exp_n = 0;
    endtask

    initial begin
        exp_n = 0;
        for (int i = 0; i < 64; i++) mem[i] = 64'd0;
        repeat (3) @(negedge clk);
        chk("R9 reset state", {wr_valid, pipe_start, chan_sel, stat_busy, done_irq, err_irq,
                               mem_req_valid, stat_count}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R4 R5 R6: sweep of lengths, wait patterns and tag mixes
        for (int n = 2; n <= 14; n++)
            for (int wm = 0; wm <= 2; wm++) begin
                logic [31:0] b = 32'h1000 + 32'(8 * ((n * 5 + wm * 17) % 64));
                for (int i = 0; i < n - 2; i++) begin
                    int s = (i * 3 + n + wm) % 5;
                    logic [15:0] tg = (s < 4) ? lane_tag[s] : (lane_tag[i % 4] & 16'hFFFE);
                    put(b, i, ent(tg, 32'hA000_0000 ^ 32'(n << 16) ^ 32'(wm << 8) ^ 32'(i),
                                  16'h0100 + 16'(i * 4 + n)));
                end
                put_tail(b, n - 2);
                run("sweep", n, wm, b, 1'b0, 1, 1'b0);
                chk("R10 channel idle", 64'(chan_sel), 64'd0);
            end

        // R8: unknown armed tag
        put(32'h2000, 0, ent(lane_tag[0], 32'h1234, 16'h0010));
        put(32'h2000, 1, ent(UNK, 32'h55, 16'h0020));
        put_tail(32'h2000, 2);
        run("R8 unknown tag", 4, 1, 32'h2000, 1'b1, 1, 1'b0);
        // R8: control tag, unused offset
        put(32'h2000, 0, ent(CTL, 32'h1, 16'h000C));
        put_tail(32'h2000, 1);
        run("R8 bad ctrl offset", 3, 0, 32'h2000, 1'b1, 1, 1'b0);
        // R7: wrong start word
        put(32'h2000, 0, ent(BAR, 32'h0, 16'h0));
        put(32'h2000, 1, ent(CTL, 32'h1C, 16'h0008));
        run("R7 bad word", 2, 0, 32'h2000, 1'b1, 0, 1'b0);
        // R7: no barrier before start
        put(32'h2000, 0, ent(lane_tag[1], 32'h9, 16'h0004));
        put(32'h2000, 1, ent(CTL, 32'h1D, 16'h0008));
        run("R7 no barrier", 2, 2, 32'h2000, 1'b1, 0, 1'b0);
        // R2 R7: unarmed barrier does not count
        put(32'h2000, 0, ent(16'h0040, 32'h0, 16'h0));
        put(32'h2000, 1, ent(CTL, 32'h1D, 16'h0008));
        run("R7 unarmed barrier", 2, 0, 32'h2000, 1'b1, 0, 1'b0);
        // R7: early start then proper tail
        put_tail(32'h2000, 0);
        put_tail(32'h2000, 2);
        run("R7 early start", 4, 1, 32'h2000, 1'b1, 1, 1'b0);
        // R7: single entry
        put(32'h2000, 0, ent(CTL, 32'h1D, 16'h0008));
        run("R7 single entry", 1, 0, 32'h2000, 1'b1, 0, 1'b0);
        // R3: start and base change while busy are ignored
        for (int i = 0; i < 6; i++) put(32'h3000, i, ent(lane_tag[i % 4], 32'(i * 7), 16'(i)));
        put_tail(32'h3000, 6);
        run("R3 busy start", 8, 2, 32'h3000, 1'b0, 1, 1'b1);

        // R10: pointer register, auto flip
        put(32'h2800, 0, ent(CTL, 32'h3, 16'h0004));
        put_tail(32'h2800, 1);
        run("R10 ptr set", 3, 0, 32'h2800, 1'b0, 1, 1'b0);
        chk("R10 flip after set", 64'(chan_sel), 64'd0);
        put_tail(32'h2800, 0);
        run("R10 second task", 2, 1, 32'h2800, 1'b0, 1, 1'b0);
        chk("R10 flip again", 64'(chan_sel), 64'd1);
        put(32'h2800, 0, ent(CTL, 32'h1, 16'h0004));
        put_tail(32'h2800, 1);
        run("R10 fixed channel", 3, 0, 32'h2800, 1'b0, 1, 1'b0);
        chk("R10 no flip", 64'(chan_sel), 64'd1);
        put(32'h2800, 0, ent(CTL & 16'hFFFE, 32'h0, 16'h0004));
        put_tail(32'h2800, 1);
        run("R2 unarmed ptr", 3, 0, 32'h2800, 1'b0, 1, 1'b0);
        chk("R2 channel kept", 64'(chan_sel), 64'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule